// File: doc/BRIEF.md
# Streaming Ghost Road Filter

This block sits between a pattern-matching stage and a track fitter. Candidate roads arrive one at a time as the matcher finds them. Each road carries a pattern identifier, one superstrip word per detector layer, and a mask of the layers that actually hit. The filter does not wait for the end of the event. Each road is compared in parallel against every road the filter has already accepted in the current event.

Majority matching lets several patterns fire for one track when a layer is missing. The filter therefore treats two roads as the same track when they agree on every layer that both of them hit. A road found to be a duplicate is discarded. Any other road is forwarded downstream and written into the associative store.

An end-of-event beat passes through the same stream in order. When it leaves, it empties the store. If the store is full, a new road is forwarded without being stored, and a sticky overflow flag is raised until the end-of-event beat leaves.

Top module: `ghost_road_filter`

## Requirements
- R1: While reset is asserted, out_valid_o and overflow_o are 0 and in_ready_o is 1.
- R2: Beats leave in arrival order with identifier, words and mask unchanged. A beat accepted at clock edge N is presented on the output from edge N+2.
- R3: A road is dropped when some stored road of the current event shares at least one hit layer with it and has equal words on every shared hit layer. The word of layer k occupies bits [12k+11:12k], and mask bit k means layer k was hit.
- R4: A road that shares no hit layer with any stored road is forwarded, even when its words are identical to a stored road.
- R5: A road whose word differs from a stored road on at least one layer hit by both is forwarded, unless another stored road makes it a duplicate under R3.
- R6: The end-of-event beat (in_eoe_i = 1) is forwarded and never dropped. Once it has been handed off, the store is empty, so a road repeated in the next event is forwarded.
- R7: When the store already holds DEPTH roads, a non-duplicate road is forwarded and not stored, and overflow_o goes to 1. A duplicate of a stored road is still dropped. overflow_o stays at 1 until the end-of-event beat is handed off, then returns to 0.
- R8: in_ready_o is 0 while a beat is being compared or presented. While out_valid_o is 1 and out_ready_i is 0, all output fields hold steady.
- R9: The pattern identifier plays no part in the comparison. A road equal to a stored road except for its identifier is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Filter can accept a beat |
| in_id_i | input | ID_W | Pattern identifier |
| in_words_i | input | NUM_LAYERS*WORD_W | Superstrip word per layer, layer 0 in the low bits |
| in_mask_i | input | NUM_LAYERS | Layer-hit mask |
| in_eoe_i | input | 1 | Beat is an end-of-event marker; road fields are ignored |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Downstream accepts the beat |
| out_id_o | output | ID_W | Forwarded identifier |
| out_words_o | output | NUM_LAYERS*WORD_W | Forwarded words |
| out_mask_o | output | NUM_LAYERS | Forwarded mask |
| out_eoe_o | output | 1 | Forwarded end-of-event marker |
| overflow_o | output | 1 | Store overflowed in the current event |

## Verification
The assertions check the following on every cycle:
- the output holds while it is stalled (R8);
- no input is accepted while a beat is in flight (R8);
- no output appears in the cycle right after an accept (R2);
- the overflow flag persists and is cleared exactly at the end-of-event handoff (R7);
- the store is empty after that handoff (R6).

The duplicate rule itself can only be shown by the bench. It sweeps every pair of layer masks, with a differing word placed on various layers, and the expected drop or forward decision is derived from the shared mask. The bench also fills the store to show that overflowing roads bypass storage, and that identifiers do not take part in the comparison.

// File: rtl/road_pkg.sv
package road_pkg;
  localparam int unsigned DEF_LAYERS = 6;
  localparam int unsigned DEF_WORD_W = 12;
  localparam int unsigned DEF_ID_W   = 16;
  localparam int unsigned DEF_DEPTH  = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMP  = 2'd1,
    ST_OUT  = 2'd2
  } flt_state_e;
endpackage

// File: rtl/road_match.sv
module road_match #(
  parameter int unsigned NUM_LAYERS = 6,
  parameter int unsigned WORD_W     = 12
) (
  input  logic [NUM_LAYERS*WORD_W-1:0] a_words_i,
  input  logic [NUM_LAYERS-1:0]        a_mask_i,
  input  logic [NUM_LAYERS*WORD_W-1:0] b_words_i,
  input  logic [NUM_LAYERS-1:0]        b_mask_i,
  output logic                         same_o
);
  logic [NUM_LAYERS-1:0] shared;
  logic [NUM_LAYERS-1:0] layer_ok;

  assign shared = a_mask_i & b_mask_i;

  for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
    assign layer_ok[l] = !shared[l] ||
                         (a_words_i[l*WORD_W +: WORD_W] == b_words_i[l*WORD_W +: WORD_W]);
  end

  // at least one common hit layer, and no conflict on any of them
  assign same_o = (|shared) && (&layer_ok);
endmodule

// File: rtl/road_store.sv
module road_store #(
  parameter int unsigned NUM_LAYERS = 6,
  parameter int unsigned WORD_W     = 12,
  parameter int unsigned DEPTH      = 32,
  localparam int unsigned RW        = NUM_LAYERS * WORD_W,
  localparam int unsigned CW        = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  wr_i,
  input  logic [RW-1:0]         q_words_i,
  input  logic [NUM_LAYERS-1:0] q_mask_i,
  output logic                  hit_o,
  output logic                  full_o,
  output logic [CW-1:0]         count_o
);
  logic [RW-1:0]         words_q [DEPTH];
  logic [NUM_LAYERS-1:0] mask_q  [DEPTH];
  logic [CW-1:0]         cnt_q;
  logic [DEPTH-1:0]      hit_vec;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (wr_i && !full_o)   cnt_q <= cnt_q + CW'(1);
  end

  // query and write share one port: the held road is stored after comparison
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic same;

    always_ff @(posedge clk_i) begin
      if (wr_i && !full_o && (cnt_q == CW'(i))) begin
        words_q[i] <= q_words_i;
        mask_q[i]  <= q_mask_i;
      end
    end

    road_match #(
      .NUM_LAYERS(NUM_LAYERS),
      .WORD_W    (WORD_W)
    ) i_match (
      .a_words_i(words_q[i]),
      .a_mask_i (mask_q[i]),
      .b_words_i(q_words_i),
      .b_mask_i (q_mask_i),
      .same_o   (same)
    );

    assign hit_vec[i] = same && (CW'(i) < cnt_q);
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/ghost_road_filter.sv
module ghost_road_filter
  import road_pkg::*;
#(
  parameter int unsigned NUM_LAYERS = DEF_LAYERS,
  parameter int unsigned WORD_W     = DEF_WORD_W,
  parameter int unsigned ID_W       = DEF_ID_W,
  parameter int unsigned DEPTH      = DEF_DEPTH
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         in_valid_i,
  output logic                         in_ready_o,
  input  logic [ID_W-1:0]              in_id_i,
  input  logic [NUM_LAYERS*WORD_W-1:0] in_words_i,
  input  logic [NUM_LAYERS-1:0]        in_mask_i,
  input  logic                         in_eoe_i,
  output logic                         out_valid_o,
  input  logic                         out_ready_i,
  output logic [ID_W-1:0]              out_id_o,
  output logic [NUM_LAYERS*WORD_W-1:0] out_words_o,
  output logic [NUM_LAYERS-1:0]        out_mask_o,
  output logic                         out_eoe_o,
  output logic                         overflow_o
);
  localparam int unsigned RW = NUM_LAYERS * WORD_W;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  flt_state_e            state_q;
  logic [ID_W-1:0]       id_q;
  logic [RW-1:0]         words_q;
  logic [NUM_LAYERS-1:0] mask_q;
  logic                  eoe_q;
  logic                  ovf_q;
  logic                  hit;
  logic                  full;
  logic [CW-1:0]         store_cnt;
  logic                  handoff;
  logic                  store_wr;
  logic                  store_clr;

  assign in_ready_o  = (state_q == ST_IDLE);
  assign out_valid_o = (state_q == ST_OUT);
  assign handoff     = out_valid_o && out_ready_i;
  assign store_wr    = (state_q == ST_CMP) && !eoe_q && !hit;
  assign store_clr   = handoff && eoe_q;

  road_store #(
    .NUM_LAYERS(NUM_LAYERS),
    .WORD_W    (WORD_W),
    .DEPTH     (DEPTH)
  ) i_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (store_clr),
    .wr_i     (store_wr),
    .q_words_i(words_q),
    .q_mask_i (mask_q),
    .hit_o    (hit),
    .full_o   (full),
    .count_o  (store_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      id_q    <= '0;
      words_q <= '0;
      mask_q  <= '0;
      eoe_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (in_valid_i) begin
          id_q    <= in_id_i;
          words_q <= in_words_i;
          mask_q  <= in_mask_i;
          eoe_q   <= in_eoe_i;
          state_q <= ST_CMP;
        end
        ST_CMP: begin
          if (!eoe_q && hit) begin
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_OUT;
            if (!eoe_q && full) ovf_q <= 1'b1;
          end
        end
        ST_OUT: if (out_ready_i) begin
          state_q <= ST_IDLE;
          if (eoe_q) ovf_q <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_id_o    = id_q;
  assign out_words_o = words_q;
  assign out_mask_o  = mask_q;
  assign out_eoe_o   = eoe_q;
  assign overflow_o  = ovf_q;
endmodule

// File: rtl/ghost_road_filter_chk.sv
module ghost_road_filter_chk #(
  parameter int unsigned NUM_LAYERS = 6,
  parameter int unsigned WORD_W     = 12,
  parameter int unsigned ID_W       = 16,
  parameter int unsigned DEPTH      = 32,
  localparam int unsigned CW        = $clog2(DEPTH + 1)
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         in_valid_i,
  input logic                         in_ready_o,
  input logic                         out_valid_o,
  input logic                         out_ready_i,
  input logic [ID_W-1:0]              out_id_o,
  input logic [NUM_LAYERS*WORD_W-1:0] out_words_o,
  input logic [NUM_LAYERS-1:0]        out_mask_o,
  input logic                         out_eoe_o,
  input logic                         overflow_o,
  input logic [CW-1:0]                store_cnt
);
  assert_hold_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_id_o) &&
      $stable(out_words_o) && $stable(out_mask_o) && $stable(out_eoe_o));

  assert_busy_no_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  assert_min_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> !out_valid_o);

  assert_overflow_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o && !(out_valid_o && out_ready_i && out_eoe_o) |=> overflow_o);

  assert_overflow_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_eoe_o |=> !overflow_o);

  assert_store_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_eoe_o |=> store_cnt == '0);
endmodule

bind ghost_road_filter ghost_road_filter_chk #(
  .NUM_LAYERS(NUM_LAYERS),
  .WORD_W    (WORD_W),
  .ID_W      (ID_W),
  .DEPTH     (DEPTH)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_id_o   (out_id_o),
  .out_words_o(out_words_o),
  .out_mask_o (out_mask_o),
  .out_eoe_o  (out_eoe_o),
  .overflow_o (overflow_o),
  .store_cnt  (store_cnt)
);

// File: tb/test_ghost_road_filter.sv
module test_ghost_road_filter;
  localparam int CLK_PERIOD = 10;
  localparam int NL  = 6;
  localparam int WW  = 12;
  localparam int IDW = 16;
  localparam int DEP = 4;
  localparam int RW  = NL * WW;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, in_eoe, out_valid, out_ready, out_eoe, ovf;
  logic [IDW-1:0] in_id, out_id;
  logic [RW-1:0]  in_words, out_words;
  logic [NL-1:0]  in_mask, out_mask;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ghost_road_filter #(.NUM_LAYERS(NL), .WORD_W(WW), .ID_W(IDW), .DEPTH(DEP)) i_ghost_road_filter (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_id_i(in_id),
    .in_words_i(in_words), .in_mask_i(in_mask), .in_eoe_i(in_eoe),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_id_o(out_id),
    .out_words_o(out_words), .out_mask_o(out_mask), .out_eoe_o(out_eoe),
    .overflow_o(ovf)
  );

  int checks = 0;
  int errors = 0;
  int           q_id[$];
  bit           q_eoe[$];
  logic [NL-1:0] q_mask[$];

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      q_id.push_back(int'(out_id));
      q_eoe.push_back(out_eoe);
      q_mask.push_back(out_mask);
    end
  end

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qclear();
    q_id.delete(); q_eoe.delete(); q_mask.delete();
  endtask

  task automatic push(int id, logic [RW-1:0] w, logic [NL-1:0] m, bit e);
    @(negedge clk);
    in_valid = 1'b1; in_id = IDW'(id); in_words = w; in_mask = m; in_eoe = e;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [RW-1:0] mkw(int seed);
    logic [RW-1:0] w;
    for (int l = 0; l < NL; l++) w[l*WW +: WW] = WW'(seed * 97 + l * 211 + 3);
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_id = '0; in_words = '0; in_mask = '0; in_eoe = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 overflow", ovf, 0);
    rst_n = 1'b1;

    // sweep all mask pairs, differing layer d (6 = identical words)
    for (int ma = 0; ma < 64; ma++) begin
      for (int mb = 0; mb < 64; mb++) begin
        int d;
        logic [NL-1:0] sh;
        logic [RW-1:0] wa, wb;
        bit dup;
        string tag;
        d  = (ma * 7 + mb) % 7;
        wa = mkw(ma);
        wb = wa;
        if (d < 6) wb[d*WW +: WW] = wa[d*WW +: WW] ^ 12'h5A5;
        sh  = NL'(ma & mb);
        dup = (sh != 0) && (d == 6 || !sh[d]);
        tag = dup ? "R3 dup dropped" : (sh == 0 ? "R4 no shared layer" : "R5 conflict forwarded");
        qclear();
        push(0, '0, '0, 1'b1);
        push(1, wa, NL'(ma), 1'b0);
        push(2, wb, NL'(mb), 1'b0); // R9: ids differ, not compared
        repeat (3) @(negedge clk);
        chk(tag, q_id.size(), dup ? 2 : 3);
        // A repeats the previous event's road, so forwarding shows the clear (R6)
        if (q_id.size() >= 2) chk("R6 R2 first road after eoe", {q_eoe[0], q_eoe[1], 8'(q_id[1]), q_mask[1]},
                                  {1'b1, 1'b0, 8'd1, NL'(ma)});
      end
    end

    // overflow: DEP distinct roads fill the store
    qclear();
    push(0, '0, '0, 1'b1);
    for (int k = 0; k < DEP; k++) push(10 + k, mkw(100 + k), 6'h3F, 1'b0);
    repeat (3) @(negedge clk);
    chk("R7 no overflow at capacity", ovf, 0);
    push(20, mkw(200), 6'h3F, 1'b0);
    repeat (3) @(negedge clk);
    chk("R7 overflow set", ovf, 1);
    chk("R7 overflow road forwarded", q_id[$], 20);
    push(21, mkw(100), 6'h3F, 1'b0);
    repeat (3) @(negedge clk);
    chk("R7 dup dropped while full", q_id[$], 20);
    push(22, mkw(200), 6'h3F, 1'b0);
    repeat (3) @(negedge clk);
    chk("R7 overflow road not stored", q_id[$], 22);
    chk("R7 overflow still set", ovf, 1);
    push(0, '0, '0, 1'b1);
    repeat (3) @(negedge clk);
    chk("R7 overflow cleared by eoe", ovf, 0);
    chk("R6 eoe forwarded", q_eoe[$], 1);
    push(23, mkw(100), 6'h3F, 1'b0);
    repeat (3) @(negedge clk);
    chk("R6 road forwarded in new event", q_id[$], 23);

    // identifier ignored
    push(0, '0, '0, 1'b1);
    push(5, mkw(300), 6'h15, 1'b0);
    push(9, mkw(300), 6'h15, 1'b0);
    repeat (3) @(negedge clk);
    chk("R9 same road other id dropped", q_id[$], 5);

    // stall and latency
    push(0, '0, '0, 1'b1);
    repeat (3) @(negedge clk);
    @(posedge clk); #1 out_ready = 1'b0;
    push(40, mkw(400), 6'h2A, 1'b0);
    chk("R2 no output one cycle after accept", out_valid, 0);
    @(negedge clk);
    chk("R2 output two cycles after accept", out_valid, 1);
    chk("R2 id passed", out_id, 40);
    repeat (4) @(negedge clk);
    chk("R8 valid held", out_valid, 1);
    chk("R8 input stalled", in_ready, 0);
    chk("R8 id held", out_id, 40);
    chk("R8 words held", out_words, mkw(400));
    chk("R8 mask held", out_mask, 6'h2A);
    @(posedge clk); #1 out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 delivered after release", q_id[$], 40);
    chk("R8 ready again", in_ready, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule